// File: doc/BRIEF.md
# Row-Stationary Convolution Grid

This block computes one output feature map of a 2D "valid" convolution on a grid of multiply-accumulate elements arranged for row-stationary reuse. The grid has R lines of E elements, where R is the filter height and E is the number of output rows. Element (i, j) keeps filter row i in its own weight registers. It slides that row across input row i+j and adds the partial sum arriving from element (i-1, j) above it. Its result is stored locally for element (i+1, j) below.

The effect of this layout is that each filter row is shared along a horizontal line of the grid, each input row is seen by all elements on one anti-diagonal, and partial sums move down a column. The bottom element of column j therefore produces output row j.

Filter rows are written through a plain load port between frames. A frame of (R+E-1)×W signed pixels then enters as a valid/ready stream in row-major order. The E×(W-S+1) signed results leave as a valid/ready stream, also in row-major order. The output stage holds one result. While that result is held and not taken (`out_valid` high, `out_ready` low), `in_ready` is low and no pixel is accepted. This is the only source of back-pressure. Frames may follow one another with no gap.

Top module: `rs_pe_array`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Output (y, x) equals the sum over i<R and k<S of weight[i][k]·pixel[y+i][x+k]. All values are two's complement signed, and the sum is exact at AW bits.
- R3: For each frame of (R+E-1)·W accepted pixels, exactly E·(W-S+1) results are emitted, in order y-major, then x.
- R4: A cycle with `wgt_we` high and `wgt_sel` = i loads filter row i in every element of grid line i. Weight k sits at bits [k·DW +: DW] of `wgt_row`. Other rows are untouched.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` hold in the next cycle.
- R6: When the output stage is empty, `in_ready` is high. A result appears on the output in the cycle after the pixel that completes it is accepted.
- R7: Back-to-back frames are correct with no idle cycle between them. Nothing from one frame affects the next.
- R8: Changes on `wgt_row` and `wgt_sel` while `wgt_we` is low have no effect on later results.
- R9: Inputs and weights at the most negative value give the exact result, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wgt_we | input | 1 | Filter row write strobe |
| wgt_sel | input | $clog2(R) | Filter row index to write |
| wgt_row | input | S*DW | Packed filter row, weight k at bits [k*DW +: DW] |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when high with in_valid |
| in_data | input | DW | Signed pixel, row-major order |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | AW | Signed convolution result |

## Verification
The assertions assume that `out_ready` is a free-running consumer signal and that `in_valid` does not depend on `in_ready` within a cycle. They also assume that weights are loaded only when no frame is in flight. The stimulus sets `out_ready`, `in_valid` and `in_data` once per cycle, before sampling `in_ready`. It writes filter rows only between frames. Its stall patterns range from none, to one cycle in three, to long blocks. The back-pressure assertions are therefore exercised without the producer ever reacting to readiness within the same cycle.

// File: rtl/rs_array_pkg.sv
package rs_array_pkg;
  // Width that holds a sum of 'taps' signed dw x dw products exactly
  function automatic int acc_bits(input int dw, input int taps);
    return 2 * dw + $clog2(taps) + 1;
  endfunction
endpackage

// File: rtl/rs_scan.sv
module rs_scan #(
  parameter int W  = 8,
  parameter int H  = 5,
  parameter int CW = 3,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (col == CW'(W - 1)) begin
        col <= '0;
        row <= (row == RW'(H - 1)) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_pe.sv
module rs_pe #(
  parameter int ROW = 0,
  parameter int R   = 3,
  parameter int S   = 3,
  parameter int W   = 8,
  parameter int DW  = 8,
  parameter int AW  = 21,
  parameter int CW  = 3,
  parameter int SW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wgt_we,
  input  logic [SW-1:0]         wgt_sel,
  input  logic [S*DW-1:0]       wgt_row,
  input  logic                  step,
  input  logic [CW-1:0]         col,
  input  logic [DW-1:0]         pix,
  input  logic [(W-S+1)*AW-1:0] psum_in,
  output logic [(W-S+1)*AW-1:0] psum_out,
  output logic [AW-1:0]         res
);
  localparam int OW = W - S + 1;

  logic signed [DW-1:0]   w_q  [S];
  logic signed [DW-1:0]   hist [S-1];
  logic                   pos_ok;
  logic [CW-1:0]          idx;
  logic signed [AW-1:0]   acc;
  logic signed [2*DW-1:0] prod;
  logic signed [DW-1:0]   tap;

  // filter row stays resident in this element
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < S; k++) w_q[k] <= '0;
    end else if (wgt_we && wgt_sel == SW'(ROW)) begin
      for (int k = 0; k < S; k++) w_q[k] <= wgt_row[k*DW +: DW];
    end
  end

  // sliding window over the diagonal input row
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < S - 1; k++) hist[k] <= '0;
    end else if (step) begin
      for (int k = 0; k < S - 2; k++) hist[k] <= hist[k+1];
      hist[S-2] <= pix;
    end
  end

  always_comb begin
    pos_ok = (col >= CW'(S - 1));
    idx    = pos_ok ? col - CW'(S - 1) : '0;
    acc    = (ROW > 0) ? $signed(psum_in[idx*AW +: AW]) : '0;
    for (int k = 0; k < S; k++) begin
      tap  = (k < S - 1) ? hist[k] : $signed(pix);
      prod = tap * w_q[k];
      acc  = acc + {{(AW-2*DW){prod[2*DW-1]}}, prod};
    end
    res = acc;
  end

  generate
    if (ROW < R - 1) begin : g_keep
      logic [AW-1:0] buf_q [OW];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int x = 0; x < OW; x++) buf_q[x] <= '0;
        end else if (step && pos_ok) begin
          buf_q[idx] <= res;
        end
      end
      always_comb begin
        for (int x = 0; x < OW; x++) psum_out[x*AW +: AW] = buf_q[x];
      end
    end else begin : g_last
      assign psum_out = '0;
    end
  endgenerate
endmodule

// File: rtl/rs_ostage.sv
module rs_ostage #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  output logic          space
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_pe_array.sv
module rs_pe_array
  import rs_array_pkg::*;
#(
  parameter int R  = 3,
  parameter int E  = 3,
  parameter int S  = 3,
  parameter int W  = 8,
  parameter int DW = 8,
  parameter int AW = acc_bits(DW, R * S)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wgt_we,
  input  logic [$clog2(R)-1:0] wgt_sel,
  input  logic [S*DW-1:0]      wgt_row,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [AW-1:0]        out_data
);
  localparam int H  = R + E - 1;
  localparam int OW = W - S + 1;
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);
  localparam int SW = $clog2(R);

  logic          adv;
  logic          emit;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] res_sel;

  logic              step_a [R][E];
  logic [AW-1:0]     res_a  [R][E];
  logic [OW*AW-1:0]  ps_a   [R][E];

  assign adv  = in_valid && in_ready;
  assign emit = adv && (row >= RW'(R - 1)) && (col >= CW'(S - 1));

  rs_scan #(.W(W), .H(H), .CW(CW), .RW(RW)) u_scan (
    .clk(clk), .rst_n(rst_n), .adv(adv), .col(col), .row(row)
  );

  generate
    for (genvar i = 0; i < R; i++) begin : g_line
      for (genvar j = 0; j < E; j++) begin : g_elem
        assign step_a[i][j] = adv && (int'(row) == i + j);
        rs_pe #(.ROW(i), .R(R), .S(S), .W(W), .DW(DW), .AW(AW), .CW(CW), .SW(SW)) u_pe (
          .clk(clk), .rst_n(rst_n),
          .wgt_we(wgt_we), .wgt_sel(wgt_sel), .wgt_row(wgt_row),
          .step(step_a[i][j]), .col(col), .pix(in_data),
          .psum_in((i == 0) ? '0 : ps_a[(i == 0) ? 0 : i-1][j]),
          .psum_out(ps_a[i][j]),
          .res(res_a[i][j])
        );
      end
    end
  endgenerate

  // bottom element of the active column delivers the finished sum
  always_comb begin
    res_sel = '0;
    for (int j = 0; j < E; j++) begin
      if (int'(row) == R - 1 + j) res_sel = res_a[R-1][j];
    end
  end

  rs_ostage #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .din(res_sel),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .space(in_ready)
  );
endmodule

// File: rtl/rs_pe_array_chk.sv
module rs_pe_array_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_data
);
  // R5
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  empty_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6
  result_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R6
  taken_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind rs_pe_array rs_pe_array_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_rs_pe_array.sv
module sim_rs_pe_array;
  localparam int R = 3, E = 3, S = 3, W = 8, DW = 8;
  localparam int H = R + E - 1, OW = W - S + 1, NOUT = E * OW;
  localparam int AW = 2 * DW + $clog2(R * S) + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 wgt_we = 1'b0;
  logic [$clog2(R)-1:0] wgt_sel = '0;
  logic [S*DW-1:0]      wgt_row = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [DW-1:0]        in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [AW-1:0]        out_data;

  rs_pe_array #(.R(R), .E(E), .S(S), .W(W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wgt_we(wgt_we), .wgt_sel(wgt_sel), .wgt_row(wgt_row),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, errors = 0, tick = 0;
  int wt [R][S];
  int img [H][W];
  int exp_o [NOUT];
  int got [NOUT];
  int seed = 7;

  function automatic int nxt();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", tick, 150000);
      finish_run();
    end
  end

  task automatic load_row(input int i);
    @(negedge clk);
    wgt_we  = 1'b1;
    wgt_sel = i[$clog2(R)-1:0];
    for (int k = 0; k < S; k++) wgt_row[k*DW +: DW] = wt[i][k][DW-1:0];
    @(negedge clk);
    wgt_we = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < R; i++) load_row(i);
  endtask

  task automatic fill_img(input int kind);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = (kind == 0) ? (y * W + x) % 11 - 3 : (kind == 2) ? -128 : nxt();
  endtask

  task automatic compute_ref();
    for (int y = 0; y < E; y++)
      for (int x = 0; x < OW; x++) begin
        int s = 0;
        for (int i = 0; i < R; i++)
          for (int k = 0; k < S; k++) s += wt[i][k] * img[y+i][x+k];
        exp_o[y*OW + x] = s;
      end
  endtask

  // mode 0: consumer always ready, 1: stalls one cycle in three, 2: long stall blocks
  task automatic run_frame(input string req, input int mode);
    int sent = 0, nrx = 0, cyc = 0, bp_bad = 0, lat_bad = 0;
    bit exp_next = 0, prev_hold = 0;
    logic [AW-1:0] prev_data = '0;
    compute_ref();
    while ((sent < H*W || nrx < NOUT) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 16) >= 10;
      endcase
      in_valid = (sent < H*W);
      in_data  = in_valid ? img[sent / W][sent % W][DW-1:0] : '0;
      #1;
      if (prev_hold && !(out_valid && out_data == prev_data)) bp_bad++;
      if (out_valid && !out_ready && in_ready) bp_bad++;
      if (mode == 0 && out_valid != exp_next) lat_bad++;
      if (out_valid && out_ready) begin
        if (nrx < NOUT) got[nrx] = int'($signed(out_data));
        nrx++;
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      exp_next  = 0;
      if (in_valid && in_ready) begin
        if (sent / W >= R - 1 && sent % W >= S - 1) exp_next = 1;
        sent++;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    check(nrx == NOUT, "R3", "result count", nrx, NOUT);
    for (int n = 0; n < NOUT && n < nrx; n++)
      check(got[n] == exp_o[n], req, $sformatf("result %0d", n), got[n], exp_o[n]);
    check(bp_bad == 0, "R5", "back-pressure violations", bp_bad, 0);
    if (mode == 0) check(lat_bad == 0, "R6", "one-cycle result latency", lat_bad, 0);
  endtask

  task automatic test_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic test_basic();  // R2 R4 R6: asymmetric weights expose tap order
    for (int i = 0; i < R; i++)
      for (int k = 0; k < S; k++) wt[i][k] = i * S + k - 4;
    load_all();
    fill_img(0);
    run_frame("R2", 0);
  endtask

  task automatic test_stall_light();  // R5
    fill_img(1);
    run_frame("R5", 1);
  endtask

  task automatic test_stall_heavy();  // R5
    fill_img(1);
    run_frame("R5", 2);
  endtask

  task automatic test_back_to_back();  // R7
    fill_img(1);
    run_frame("R7", 0);
    fill_img(1);
    run_frame("R7", 0);
  endtask

  task automatic test_row_reload();  // R4: only line 1 changes
    for (int k = 0; k < S; k++) wt[1][k] = nxt();
    load_row(1);
    fill_img(1);
    run_frame("R4", 0);
  endtask

  task automatic test_no_write();  // R8
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      wgt_sel = c[$clog2(R)-1:0] % R[$clog2(R)-1:0];
      wgt_row = {S{8'h5a}} ^ (S*DW)'(c * 977);
    end
    fill_img(1);
    run_frame("R8", 1);
  endtask

  task automatic test_extreme();  // R9
    for (int i = 0; i < R; i++)
      for (int k = 0; k < S; k++) wt[i][k] = -128;
    load_all();
    fill_img(2);
    run_frame("R9", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    test_reset();
    test_basic();
    test_stall_light();
    test_stall_heavy();
    test_back_to_back();
    test_row_reload();
    test_no_write();
    test_extreme();
    finish_run();
  end
endmodule